// File: doc/BRIEF.md
# SNOW 3G Word Substitution Unit

This block computes one of the two 32-bit substitutions used by the SNOW 3G stream cipher core. A parameter chooses which one: S1 or S2. The input word is split into four bytes. Each byte passes through one 256-entry byte substitution table. Byte-level logic then expands the four substituted bytes back into a full 32-bit word. That logic is a multiply-by-x unit in the byte field, followed by an XOR network arranged like a column mix.

Only four small byte tables sit in each instance, where a direct approach would use four 1-KB word tables. The tables are computed at elaboration from the field arithmetic that defines them. No table contents are stored in the source. The result is registered once, and a clock enable controls when a new word is captured. A cipher core can place one S1 instance and one S2 instance beside its FSM registers.

Top module: `snow3g_sbox32`

## Requirements
- R1: With KIND = SBOX_S1, the byte table is the AES forward byte substitution. That is the inverse in GF(2^8) modulo 0x11B (zero maps to zero), followed by the affine map with constant 0x63. The byte multiplier shifts left one bit and XORs 0x1B when the shifted-out bit was 1.
- R2: With KIND = SBOX_S2, the byte table is SQ(x) = x ^ x^9 ^ x^13 ^ x^15 ^ x^33 ^ x^41 ^ x^45 ^ x^47 ^ x^49 ^ 0x25. The powers are taken in GF(2^8) modulo 0x169. The byte multiplier uses 0x69 as its reduction constant.
- R3: Input byte 0 is din[31:24], and output byte 0 is dout[31:24]. The index decreases by one for each lower byte. With s_i the substituted input byte i and m() the byte multiplier, output byte j = m(s_j) ^ s_(j+1) ^ s_(j+2) ^ m(s_(j+3)) ^ s_(j+3), with indices taken modulo 4.
- R4: While rst_n is low, dout is 0, whatever en and din do. The reset takes effect asynchronously.
- R5: When en is high at a rising clock edge and reset is released, dout presents the substitution of the din sampled at that edge from that edge onward. The latency is one cycle.
- R6: When en is low at a rising edge, dout keeps its value even if din changes.
- R7: An all-zero input word gives 0x63636363 for S1 and 0x25252525 for S2.
- R8: An input whose four bytes are all equal to b gives an output whose four bytes are all equal to the table value of b. The multiplier terms cancel in this case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Capture enable for the output register |
| din | input | 32 | Word to substitute, byte 0 in the top bits |
| dout | output | 32 | Registered substituted word |

## Verification
The hardest case to reach from the ports is the reduction branch of the byte multiplier in every lane. The substituted byte, not the input byte, must have its top bit set, so the lanes must be driven with values whose table outputs land above 0x7F. The stimulus table mixes words with distinct bytes in each lane and compares them against word-level tables that the bench builds independently. Those tables cover the reduction path in all four positions. Replicated-byte and all-zero words then isolate the lane ordering from the multiplier.

// File: rtl/snow3g_sbox_pkg.sv
package snow3g_sbox_pkg;

  typedef enum logic [0:0] {SBOX_S1 = 1'b0, SBOX_S2 = 1'b1} sbox_kind_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = 4;
  localparam int unsigned WORD_W  = BYTE_W * LANES;
  localparam int unsigned ENTRIES = 1 << BYTE_W;
  localparam int unsigned TBL_W   = BYTE_W * ENTRIES;

  // low byte of the field polynomial, also the byte multiplier constant
  function automatic logic [7:0] red_const(sbox_kind_e kind);
    return (kind == SBOX_S1) ? 8'h1B : 8'h69;
  endfunction

  // Horner-style field product, high bit of b first
  function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b, logic [7:0] red);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      acc = {acc[6:0], 1'b0} ^ (acc[7] ? red : 8'h00);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [7:0] aes_byte(logic [7:0] x);
    logic [7:0] p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127, inv;
    p2   = fmul(x, x, 8'h1B);
    p3   = fmul(p2, x, 8'h1B);
    p6   = fmul(p3, p3, 8'h1B);
    p7   = fmul(p6, x, 8'h1B);
    p14  = fmul(p7, p7, 8'h1B);
    p15  = fmul(p14, x, 8'h1B);
    p30  = fmul(p15, p15, 8'h1B);
    p31  = fmul(p30, x, 8'h1B);
    p62  = fmul(p31, p31, 8'h1B);
    p63  = fmul(p62, x, 8'h1B);
    p126 = fmul(p63, p63, 8'h1B);
    p127 = fmul(p126, x, 8'h1B);
    inv  = fmul(p127, p127, 8'h1B);
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] sq_byte(logic [7:0] x);
    logic [7:0] x2, x4, x8, x16, x32, x9, x13, x15, x33, x41, x45, x47, x49;
    x2  = fmul(x, x, 8'h69);
    x4  = fmul(x2, x2, 8'h69);
    x8  = fmul(x4, x4, 8'h69);
    x16 = fmul(x8, x8, 8'h69);
    x32 = fmul(x16, x16, 8'h69);
    x9  = fmul(x8, x, 8'h69);
    x13 = fmul(x9, x4, 8'h69);
    x15 = fmul(x13, x2, 8'h69);
    x33 = fmul(x32, x, 8'h69);
    x41 = fmul(x33, x8, 8'h69);
    x45 = fmul(x41, x4, 8'h69);
    x47 = fmul(x45, x2, 8'h69);
    x49 = fmul(x47, x2, 8'h69);
    return x ^ x9 ^ x13 ^ x15 ^ x33 ^ x41 ^ x45 ^ x47 ^ x49 ^ 8'h25;
  endfunction

  function automatic logic [TBL_W-1:0] build_base(sbox_kind_e kind);
    logic [TBL_W-1:0] tbl;
    tbl = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      tbl[i*BYTE_W +: BYTE_W] = (kind == SBOX_S1) ? aes_byte(8'(i)) : sq_byte(8'(i));
    end
    return tbl;
  endfunction

endpackage

// File: rtl/snow3g_sbox_lane.sv
module snow3g_sbox_lane
  import snow3g_sbox_pkg::*;
#(
  parameter sbox_kind_e KIND = SBOX_S1
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BYTE_W-1:0] sub,
  output logic [BYTE_W-1:0] sub_x
);
  localparam logic [TBL_W-1:0]  BASE = build_base(KIND);
  localparam logic [BYTE_W-1:0] RED  = red_const(KIND);

  always_comb begin
    sub   = BASE[{byte_in, 3'b000} +: BYTE_W];
    sub_x = {sub[BYTE_W-2:0], 1'b0} ^ (sub[BYTE_W-1] ? RED : '0);
  end
endmodule

// File: rtl/snow3g_sbox_mix.sv
module snow3g_sbox_mix
  import snow3g_sbox_pkg::*;
(
  input  logic [LANES-1:0][BYTE_W-1:0] sub,
  input  logic [LANES-1:0][BYTE_W-1:0] sub_x,
  output logic [WORD_W-1:0]            word
);
  // lane index 0 is the most significant byte
  for (genvar j = 0; j < LANES; j++) begin : g_col
    localparam int unsigned J1 = (j + 1) % LANES;
    localparam int unsigned J2 = (j + 2) % LANES;
    localparam int unsigned J3 = (j + 3) % LANES;
    assign word[WORD_W-1-j*BYTE_W -: BYTE_W] =
      sub_x[j] ^ sub[J1] ^ sub[J2] ^ sub_x[J3] ^ sub[J3];
  end
endmodule

// File: rtl/snow3g_sbox32.sv
module snow3g_sbox32
  import snow3g_sbox_pkg::*;
#(
  parameter sbox_kind_e KIND = SBOX_S1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [LANES-1:0][BYTE_W-1:0] sub;
  logic [LANES-1:0][BYTE_W-1:0] sub_x;
  logic [WORD_W-1:0]            mixed;
  logic [WORD_W-1:0]            dout_q;
  logic [WORD_W-1:0]            dout_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    snow3g_sbox_lane #(.KIND(KIND)) u_lane (
      .byte_in(din[WORD_W-1-i*BYTE_W -: BYTE_W]),
      .sub    (sub[i]),
      .sub_x  (sub_x[i])
    );
  end

  snow3g_sbox_mix u_mix (
    .sub  (sub),
    .sub_x(sub_x),
    .word (mixed)
  );

  always_comb begin
    dout_d = dout_q;
    if (en) dout_d = mixed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/snow3g_sbox32_chk.sv
module snow3g_sbox32_chk
  import snow3g_sbox_pkg::*;
#(
  parameter sbox_kind_e KIND = SBOX_S1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [WORD_W-1:0] din,
  input logic [WORD_W-1:0] dout
);
  localparam logic [WORD_W-1:0] ZERO_IMG = (KIND == SBOX_S1) ? 32'h63636363 : 32'h25252525;

  logic din_repl;
  logic dout_repl;
  assign din_repl  = (din[31:24] == din[23:16]) && (din[23:16] == din[15:8]) && (din[15:8] == din[7:0]);
  assign dout_repl = (dout[31:24] == dout[23:16]) && (dout[23:16] == dout[15:8]) && (dout[15:8] == dout[7:0]);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r4_reset_clear: assert (dout == '0);
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dout));

  a_r7_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din == '0) |=> (dout == ZERO_IMG));

  a_r8_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (en && din_repl) |=> dout_repl);

  a_r5_known: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> !$isunknown(dout));
endmodule

bind snow3g_sbox32 snow3g_sbox32_chk #(.KIND(KIND)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .en   (en),
  .din  (din),
  .dout (dout)
);

// File: tb/test_snow3g_sbox32.sv
module test_snow3g_sbox32;
  import snow3g_sbox_pkg::*;

  localparam time CLK_PERIOD = 10;
  localparam int  NVEC = 12;
  localparam logic [31:0] STIM [NVEC] = '{
    32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h80FF7F01,
    32'hDEADBEEF, 32'h0000FF00, 32'hC0FFEE11, 32'h55AA33CC,
    32'h13579BDF, 32'hF00DCAFE, 32'h7E8191A2, 32'h02040810
  };

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] din;
  logic [31:0] dout1;
  logic [31:0] dout2;

  int n_cmp;
  int n_bad;
  bit done;

  logic [31:0] t1 [4][256];
  logic [31:0] t2 [4][256];

  snow3g_sbox32 #(.KIND(SBOX_S1)) i_snow3g_sbox32 (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout1));
  snow3g_sbox32 #(.KIND(SBOX_S2)) i_snow3g_sbox32_s2 (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .dout(dout2));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b, logic [7:0] red);
    logic [7:0] p;
    logic       hi;
    p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[0]) p = p ^ a;
      hi = a[7];
      a  = {a[6:0], 1'b0};
      if (hi) a = a ^ red;
      b = b >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] m_aes(logic [7:0] x);
    logic [7:0] inv;
    inv = 8'h00;
    for (int y = 1; y < 256; y++) begin
      if (m_mul(x, 8'(y), 8'h1B) == 8'h01) inv = 8'(y);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] m_sq(logic [7:0] x);
    logic [7:0] p;
    logic [7:0] acc;
    p   = 8'h01;
    acc = 8'h25;
    for (int k = 1; k <= 49; k++) begin
      p = m_mul(p, x, 8'h69);
      if (k == 1 || k == 9 || k == 13 || k == 15 || k == 33 ||
          k == 41 || k == 45 || k == 47 || k == 49) acc = acc ^ p;
    end
    return acc;
  endfunction

  function automatic logic [7:0] m_x(logic [7:0] v, logic [7:0] red);
    return v[7] ? ({v[6:0], 1'b0} ^ red) : {v[6:0], 1'b0};
  endfunction

  task automatic build_tables();
    logic [7:0] s, m;
    for (int b = 0; b < 256; b++) begin
      for (int k = 0; k < 2; k++) begin
        s = (k == 0) ? m_aes(8'(b)) : m_sq(8'(b));
        m = m_x(s, (k == 0) ? 8'h1B : 8'h69);
        for (int i = 0; i < 4; i++) begin
          logic [31:0] w;
          w = '0;
          for (int j = 0; j < 4; j++) begin
            logic [7:0] c;
            if (j == i) c = m;
            else if (j == (i + 1) % 4) c = m ^ s;
            else c = s;
            w[31-8*j -: 8] = c;
          end
          if (k == 0) t1[i][b] = w; else t2[i][b] = w;
        end
      end
    end
  endtask

  function automatic logic [31:0] ref1(logic [31:0] w);
    return t1[0][w[31:24]] ^ t1[1][w[23:16]] ^ t1[2][w[15:8]] ^ t1[3][w[7:0]];
  endfunction
  function automatic logic [31:0] ref2(logic [31:0] w);
    return t2[0][w[31:24]] ^ t2[1][w[23:16]] ^ t2[2][w[15:8]] ^ t2[3][w[7:0]];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    din = w;
    en  = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    en    = 1'b1;
    din   = 32'hA5A5A5A5;
    build_tables();

    // R4: reset holds zero even with enable high
    repeat (3) @(negedge clk);
    check("R4 reset S1", dout1, 32'h0);
    check("R4 reset S2", dout2, 32'h0);
    rst_n = 1'b1;

    // R1 R2 R3 R5: vector walk with mixed lane values
    for (int v = 0; v < NVEC; v++) begin
      apply(STIM[v]);
      check("R1 R3 R5 S1 vector", dout1, ref1(STIM[v]));
      check("R2 R3 R5 S2 vector", dout2, ref2(STIM[v]));
    end

    // R7: all-zero word
    apply(32'h0);
    check("R7 zero S1", dout1, 32'h63636363);
    check("R7 zero S2", dout2, 32'h25252525);

    // R8: replicated bytes
    apply(32'h01010101);
    check("R8 replicated S1", dout1, {4{m_aes(8'h01)}});
    check("R8 replicated S2", dout2, {4{m_sq(8'h01)}});
    apply(32'hFFFFFFFF);
    check("R8 replicated S1 ff", dout1, {4{m_aes(8'hFF)}});
    check("R8 replicated S2 ff", dout2, {4{m_sq(8'hFF)}});

    // R3: single nonzero lane, one per position
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'h0;
      w[31-8*i -: 8] = 8'hC3;
      apply(w);
      check("R3 lane position S1", dout1, ref1(w));
      check("R3 lane position S2", dout2, ref2(w));
    end

    // R6: enable low holds the output while din moves
    apply(32'h3C5A7E91);
    @(negedge clk);
    en  = 1'b0;
    din = 32'h11223344;
    @(negedge clk);
    din = 32'h99887766;
    @(negedge clk);
    check("R6 hold S1", dout1, ref1(32'h3C5A7E91));
    check("R6 hold S2", dout2, ref2(32'h3C5A7E91));

    // R4: asynchronous reset in mid-run
    en = 1'b1;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R4 async reset S1", dout1, 32'h0);
    check("R4 async reset S2", dout2, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(32'h0BADF00D);
    check("R5 after reset S1", dout1, ref1(32'h0BADF00D));
    check("R5 after reset S2", dout2, ref2(32'h0BADF00D));

    finish_run();
  end
endmodule